// File: doc/BRIEF.md
# Emulator Control Register Bank

A 32-bit register bank that governs an emulated core as a whole. A simple word bus reaches it through a write strobe, a read strobe, a byte address, write data and read data. Reads are registered: the data for a read strobe appears on `bus_rdata_o` after the next clock edge and stays there until the next read.

The bank holds several kinds of state. A target-rate word is given in eighths of a hertz. A mode bit chooses between free-running toward the target rate and single-stepping. Two write-fired commands start phase 0 or phase 1 of a step, and each reads back as the live "phase settled" status from the stepping block. A cycle counter counts completed emulated clock cycles and is read as a low and a high part. A pad-input image holds the level of each external pin. A guarded command word triggers a full reset of the emulator, but only when one exact key value is written. Command pulses and configuration levels go to a separate clock stepping block, which returns the cycle-completion and phase status.

Top module: `emu_ctrl_regs`

## Requirements
- R1: After the active-low reset, the rate word reads 1000000000, the mode bit and the pad image read 0, the counter reads 0, and all pulse outputs are low.
- R2: Offset 0x04 (rate) and offset 0x1C (pad image; bit n is the level of pin n) are read/write. Their values appear on `rate_o` and `pad_o` one clock after the write.
- R3: At offset 0x08 only bit 0 is stored (0 = target-rate mode, 1 = single-step mode). It drives `step_mode_o`, and bits 31:1 read as 0.
- R4: A write of any value to offset 0x0C raises `trig_p0_o` for exactly one clock, starting at the edge that samples the write. Offset 0x10 does the same for `trig_p1_o`. No filtering by mode is applied.
- R5: A read of 0x0C returns 1 only when `step_phase_i` is 0 and `phase_settled_i` is 1. A read of 0x10 returns 1 only when `step_phase_i` is 1 and `phase_settled_i` is 1. Both return 0 otherwise.
- R6: The counter adds one at each clock where `cycle_done_i` is high and wraps at 2^CNT_W. Offset 0x14 returns bits CNT_LO_W-1:0 and offset 0x18 returns the bits above them, zero-extended (defaults: 64 bits split 32/32).
- R7: A write of exactly 0xA55A5AA5 to offset 0x00 returns the rate, the mode, the pad image and the counter to their reset values at that edge. It also raises `full_rst_o` for exactly one clock. A clear of the counter wins over a simultaneous `cycle_done_i`.
- R8: A write of any other value to offset 0x00 changes no register and does not raise `full_rst_o`.
- R9: Reads of offset 0x00 and of any unmapped address (including addresses that are not word-aligned) return 0. Writes to 0x14, 0x18 and unmapped addresses change nothing.
- R10: `bus_rdata_o` takes the value selected by the address at an edge where `bus_re_i` is high, using the state before that edge. It holds while `bus_re_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address within the bank |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| cycle_done_i | input | 1 | One emulated clock cycle completed |
| step_phase_i | input | 1 | Current step phase (0 or 1) |
| phase_settled_i | input | 1 | Current phase has settled |
| full_rst_o | output | 1 | One-clock full-reset pulse |
| rate_o | output | 32 | Target rate in 1/8 Hz |
| step_mode_o | output | 1 | 1 = single-step mode |
| trig_p0_o | output | 1 | One-clock phase-0 trigger |
| trig_p1_o | output | 1 | One-clock phase-1 trigger |
| pad_o | output | PAD_W | Pad-input image |

## Verification
The bench builds the bank with CNT_W = 12 and CNT_LO_W = 4, and keeps the default address, pad and rate parameters. With this split, the carry from the low part into the high part happens after 16 completed cycles and the full wrap after 4096. Both are reached in a short run. This exercises the split read of the counter and its wrap, which the 64-bit default would place far out of reach. Random traffic, which sometimes carries the reset key, is compared clock by clock against a behavioural model.

// File: rtl/emu_regs_pkg.sv
package emu_regs_pkg;
  localparam int DW = 32;

  localparam int OFF_CMD    = 'h00;
  localparam int OFF_RATE   = 'h04;
  localparam int OFF_MODE   = 'h08;
  localparam int OFF_TRIG0  = 'h0C;
  localparam int OFF_TRIG1  = 'h10;
  localparam int OFF_CNT_LO = 'h14;
  localparam int OFF_CNT_HI = 'h18;
  localparam int OFF_PAD    = 'h1C;

  localparam logic [DW-1:0] RST_KEY = 32'hA55A_5AA5;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CMD,
    SEL_RATE,
    SEL_MODE,
    SEL_TRIG0,
    SEL_TRIG1,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_PAD
  } reg_sel_e;
endpackage

// File: rtl/emu_addr_dec.sv
module emu_addr_dec
  import emu_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(OFF_CMD))    sel_o = SEL_CMD;
    else if (addr_i == ADDR_W'(OFF_RATE))   sel_o = SEL_RATE;
    else if (addr_i == ADDR_W'(OFF_MODE))   sel_o = SEL_MODE;
    else if (addr_i == ADDR_W'(OFF_TRIG0))  sel_o = SEL_TRIG0;
    else if (addr_i == ADDR_W'(OFF_TRIG1))  sel_o = SEL_TRIG1;
    else if (addr_i == ADDR_W'(OFF_CNT_LO)) sel_o = SEL_CNT_LO;
    else if (addr_i == ADDR_W'(OFF_CNT_HI)) sel_o = SEL_CNT_HI;
    else if (addr_i == ADDR_W'(OFF_PAD))    sel_o = SEL_PAD;
  end
endmodule

// File: rtl/emu_cycle_ctr.sv
module emu_cycle_ctr #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/emu_rd_mux.sv
module emu_rd_mux
  import emu_regs_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int CNT_LO_W = 32,
  parameter int PAD_W    = 32
) (
  input  reg_sel_e          sel_i,
  input  logic [DW-1:0]     rate_i,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [PAD_W-1:0]  pad_i,
  input  logic              phase_i,
  input  logic              settled_i,
  output logic [DW-1:0]     data_o
);
  localparam int HI_W = CNT_W - CNT_LO_W;

  logic [DW-1:0] cnt_lo, cnt_hi;

  assign cnt_lo = DW'(cnt_i[CNT_LO_W-1:0]);
  assign cnt_hi = DW'(cnt_i[CNT_W-1:CNT_LO_W]);

  always_comb begin
    unique case (sel_i)
      SEL_RATE:   data_o = rate_i;
      SEL_MODE:   data_o = DW'(mode_i);
      SEL_TRIG0:  data_o = DW'(!phase_i && settled_i);
      SEL_TRIG1:  data_o = DW'(phase_i && settled_i);
      SEL_CNT_LO: data_o = cnt_lo;
      SEL_CNT_HI: data_o = cnt_hi;
      SEL_PAD:    data_o = DW'(pad_i);
      default:    data_o = '0;
    endcase
  end

  if (HI_W > DW || CNT_LO_W > DW || PAD_W > DW) begin : g_bad_cfg
    initial $error("emu_rd_mux: field wider than data word");
  end
endmodule

// File: rtl/emu_ctrl_regs.sv
module emu_ctrl_regs
  import emu_regs_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          CNT_W    = 64,
  parameter int          CNT_LO_W = 32,
  parameter int          PAD_W    = 32,
  parameter logic [31:0] RATE_RST = 32'd1_000_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              cycle_done_i,
  input  logic              step_phase_i,
  input  logic              phase_settled_i,
  output logic              full_rst_o,
  output logic [31:0]       rate_o,
  output logic              step_mode_o,
  output logic              trig_p0_o,
  output logic              trig_p1_o,
  output logic [PAD_W-1:0]  pad_o
);
  reg_sel_e         sel;
  logic             key_hit;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    rd_data;

  emu_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  assign key_hit = bus_we_i && (sel == SEL_CMD) && (bus_wdata_i == RST_KEY);

  // configuration registers; key write acts as a synchronous full reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_o      <= RATE_RST;
      step_mode_o <= 1'b0;
      pad_o       <= '0;
    end else if (key_hit) begin
      rate_o      <= RATE_RST;
      step_mode_o <= 1'b0;
      pad_o       <= '0;
    end else if (bus_we_i) begin
      unique case (sel)
        SEL_RATE: rate_o      <= bus_wdata_i;
        SEL_MODE: step_mode_o <= bus_wdata_i[0];
        SEL_PAD:  pad_o       <= bus_wdata_i[PAD_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_rst_o <= 1'b0;
      trig_p0_o  <= 1'b0;
      trig_p1_o  <= 1'b0;
    end else begin
      full_rst_o <= key_hit;
      trig_p0_o  <= bus_we_i && (sel == SEL_TRIG0);
      trig_p1_o  <= bus_we_i && (sel == SEL_TRIG1);
    end
  end

  emu_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (key_hit),
    .inc_i  (cycle_done_i),
    .cnt_o  (cnt_q)
  );

  emu_rd_mux #(.CNT_W(CNT_W), .CNT_LO_W(CNT_LO_W), .PAD_W(PAD_W)) u_mux (
    .sel_i     (sel),
    .rate_i    (rate_o),
    .mode_i    (step_mode_o),
    .cnt_i     (cnt_q),
    .pad_i     (pad_o),
    .phase_i   (step_phase_i),
    .settled_i (phase_settled_i),
    .data_o    (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_re_i) bus_rdata_o <= rd_data;
  end
endmodule

// File: rtl/emu_ctrl_regs_chk.sv
module emu_ctrl_regs_chk
  import emu_regs_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          CNT_W    = 64,
  parameter int          PAD_W    = 32,
  parameter logic [31:0] RATE_RST = 32'd1_000_000_000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic              bus_re_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic              cycle_done_i,
  input logic              full_rst_o,
  input logic [31:0]       rate_o,
  input logic              step_mode_o,
  input logic              trig_p0_o,
  input logic              trig_p1_o,
  input logic [PAD_W-1:0]  pad_o,
  input logic [CNT_W-1:0]  cnt_i
);
  logic cmd_wr, key_wr;
  assign cmd_wr = bus_we_i && (bus_addr_i == ADDR_W'(OFF_CMD));
  assign key_wr = cmd_wr && (bus_wdata_i == RST_KEY);

  // R4
  trig0_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(OFF_TRIG0)) |=> trig_p0_o);
  // R4
  trig0_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_p0_o |-> $past(bus_we_i && bus_addr_i == ADDR_W'(OFF_TRIG0)));
  // R4
  trig1_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(OFF_TRIG1)) |=> trig_p1_o);
  // R4
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trig_p0_o, trig_p1_o, full_rst_o}));
  // R7
  key_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr |=> full_rst_o && rate_o == RATE_RST && !step_mode_o && pad_o == '0 && cnt_i == '0);
  // R8
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !key_wr) |=> !full_rst_o && $stable(rate_o) && $stable(pad_o) && $stable(step_mode_o));
  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_done_i && !key_wr) |=> cnt_i == $past(cnt_i) + CNT_W'(1));
  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |=> $stable(bus_rdata_o));
endmodule

bind emu_ctrl_regs emu_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAD_W(PAD_W), .RATE_RST(RATE_RST)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_we_i     (bus_we_i),
  .bus_re_i     (bus_re_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .cycle_done_i (cycle_done_i),
  .full_rst_o   (full_rst_o),
  .rate_o       (rate_o),
  .step_mode_o  (step_mode_o),
  .trig_p0_o    (trig_p0_o),
  .trig_p1_o    (trig_p1_o),
  .pad_o        (pad_o),
  .cnt_i        (cnt_q)
);

// File: tb/emu_ctrl_regs_test.sv
`timescale 1ns/1ps
module emu_ctrl_regs_test;
  localparam int CNT_W = 12;
  localparam int LO_W  = 4;
  localparam int RATE0 = 1000000000;
  localparam int KEY   = 32'hA55A5AA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, re = 0, done = 0, phase = 0, settled = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, rate;
  logic [31:0] pad;
  logic full_rst, mode, t0, t1;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  emu_ctrl_regs #(.CNT_W(CNT_W), .CNT_LO_W(LO_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cycle_done_i(done), .step_phase_i(phase), .phase_settled_i(settled),
    .full_rst_o(full_rst), .rate_o(rate), .step_mode_o(mode),
    .trig_p0_o(t0), .trig_p1_o(t1), .pad_o(pad)
  );

  // behavioural reference
  int unsigned m_rate, m_pad, m_rd, m_cnt;
  bit m_mode, m_rst, m_t0, m_t1;

  function automatic int unsigned ref_read(logic [7:0] a);
    case (a)
      8'h04: return m_rate;
      8'h08: return m_mode;
      8'h0C: return (!phase && settled) ? 1 : 0;
      8'h10: return (phase && settled) ? 1 : 0;
      8'h14: return m_cnt % (1 << LO_W);
      8'h18: return m_cnt / (1 << LO_W);
      8'h1C: return m_pad;
      default: return 0;
    endcase
  endfunction

  function automatic bit key_write();
    return we && addr == 8'h00 && wdata == KEY;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rate <= RATE0; m_pad <= 0; m_mode <= 0; m_cnt <= 0; m_rd <= 0;
      m_rst <= 0; m_t0 <= 0; m_t1 <= 0;
    end else begin
      m_rst <= key_write();
      m_t0  <= we && addr == 8'h0C;
      m_t1  <= we && addr == 8'h10;
      if (re) m_rd <= ref_read(addr);
      if (key_write()) begin
        m_rate <= RATE0; m_pad <= 0; m_mode <= 0; m_cnt <= 0;
      end else begin
        if (we) begin
          if (addr == 8'h04) m_rate <= wdata;
          if (addr == 8'h08) m_mode <= wdata[0];
          if (addr == 8'h1C) m_pad  <= wdata;
        end
        if (done) m_cnt <= (m_cnt + 1) % (1 << CNT_W);
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2 rate_o", rate, m_rate);
    chk("R2 pad_o", pad, m_pad);
    chk("R3 step_mode_o", mode, m_mode);
    chk("R4 trig_p0_o", t0, m_t0);
    chk("R4 trig_p1_o", t1, m_t1);
    chk("R7 full_rst_o", full_rst, m_rst);
    chk("R10 bus_rdata_o", rdata, m_rd);
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); re = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 full_rst_o", full_rst, 0);
    chk("R1 trig", {t0, t1}, 0);
    rd(8'h04, RATE0, "R1 rate");
    rd(8'h08, 0, "R1 mode");
    rd(8'h1C, 0, "R1 pad");
    rd(8'h14, 0, "R1 cnt lo");
    // R2 read/write
    wr(8'h04, 32'h1234_5678);
    rd(8'h04, 32'h1234_5678, "R2 rate rw");
    wr(8'h1C, 32'hA5A5_0F0F);
    rd(8'h1C, 32'hA5A5_0F0F, "R2 pad rw");
    chk("R2 pad pin 0", pad[0], 1);
    // R3 mode bit only
    wr(8'h08, 32'hFFFF_FFFF);
    chk("R3 step mode on", mode, 1);
    rd(8'h08, 1, "R3 mode readback");
    wr(8'h08, 32'hFFFF_FFFE);
    rd(8'h08, 0, "R3 mode bit0 clear");
    // R4 triggers, target-rate mode: no filtering
    wr(8'h0C, 32'h0);
    chk("R4 trig0 high", t0, 1);
    @(negedge clk);
    chk("R4 trig0 one clock", t0, 0);
    wr(8'h10, 32'h55);
    chk("R4 trig1 high", {t0, t1}, 1);
    @(negedge clk);
    chk("R4 trig1 one clock", t1, 0);
    // R5 phase status
    phase = 0; settled = 1;
    rd(8'h0C, 1, "R5 p0 settled");
    rd(8'h10, 0, "R5 p1 in p0");
    phase = 1;
    rd(8'h0C, 0, "R5 p0 in p1");
    rd(8'h10, 1, "R5 p1 settled");
    settled = 0;
    rd(8'h10, 0, "R5 p1 unsettled");
    // R6 counter split and wrap
    @(negedge clk); done = 1;
    repeat (20) @(negedge clk);
    done = 0;
    rd(8'h14, 20 % 16, "R6 cnt lo");
    rd(8'h18, 20 / 16, "R6 cnt hi");
    done = 1;
    repeat (4096) @(negedge clk);
    done = 0;
    rd(8'h14, 4, "R6 wrap lo");
    rd(8'h18, 1, "R6 wrap hi");
    // R8 near-miss key
    wr(8'h00, 32'hA55A_5AA4);
    chk("R8 no reset pulse", full_rst, 0);
    rd(8'h04, 32'h1234_5678, "R8 rate kept");
    rd(8'h14, 4, "R8 cnt kept");
    // R9 unmapped and read-only
    rd(8'h00, 0, "R9 cmd reads 0");
    rd(8'h20, 0, "R9 unmapped");
    rd(8'h05, 0, "R9 unaligned");
    wr(8'h14, 32'hFF);
    wr(8'h18, 32'hFF);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h14, 4, "R9 ro lo");
    rd(8'h18, 1, "R9 ro hi");
    rd(8'h1C, 32'hA5A5_0F0F, "R9 pad untouched");
    // R7 key reset, with simultaneous cycle_done
    @(negedge clk); we = 1; addr = 8'h00; wdata = KEY; done = 1;
    @(negedge clk); we = 0; done = 0;
    chk("R7 pulse", full_rst, 1);
    chk("R7 rate", rate, RATE0);
    chk("R7 pad", pad, 0);
    @(negedge clk);
    chk("R7 pulse one clock", full_rst, 0);
    rd(8'h14, 0, "R7 cnt cleared");
    // R10 hold
    rd(8'h04, RATE0, "R10 read");
    repeat (3) @(negedge clk);
    chk("R10 hold", rdata, RATE0);
    // random traffic against model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      we = ($urandom % 3) == 0;
      re = ($urandom % 2) == 0;
      case ($urandom % 10)
        8: addr = 8'h20;
        9: addr = 8'h05;
        default: addr = 8'(($urandom % 8) * 4);
      endcase
      wdata = (($urandom % 6) == 0) ? KEY : $urandom;
      done = $urandom % 2;
      phase = $urandom % 2;
      settled = $urandom % 2;
    end
    @(negedge clk); we = 0; re = 0; done = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule